// File: doc/BRIEF.md
# Binary search tree insertion engine

This block grows a binary sorting tree inside an external single-port node memory, one key at a time. Keys arrive on a valid/ready stream. For every key that is accepted and in range, the engine starts at the root and reads one node per cycle. At each node it compares the new key with the stored key and follows the left or right link until it reaches a null link. It then writes the new node into the next unused word and rewrites the parent word with the link field updated.

Out-of-range keys are taken from the stream and thrown away. The engine drives the memory port only while it is busy. When it is idle, another agent, such as an in-order traversal engine, can use the same memory. The root address and the number of stored nodes are always visible at the outputs.

Top module: `bst_insert_engine`

## Requirements
- R1: After reset, idle=1, in_ready=1, node_count=0 and root_addr=0.
- R2: A node word is {key[25:12], left[11:6], right[5:0]} (14-bit key, 6-bit links). Link value 0 means no child. The engine never writes address 0.
- R3: The first stored key is written at address 1. From then on, root_addr is 1 and does not change.
- R4: A key smaller than the node key goes into the left subtree. A key greater than or equal to the node key goes into the right subtree, so duplicate keys are stored.
- R5: Nodes are allocated in sequence at addresses 1, 2, 3 and so on. A new node is written with both links 0. The parent's chosen link field is then rewritten to hold the new address, and its other fields are kept. node_count rises by exactly one per stored key.
- R6: A key above 9999 is accepted (in_ready=1) but dropped. Nothing is written, node_count does not change, and the engine stays idle.
- R7: A key is accepted only while idle=1. Suppose a non-first key's parent lies at depth d, where the root has depth 0. Then idle is 0 for exactly d+4 cycles after acceptance.
- R8: When node_count reaches 63, in_ready goes low and further valid keys change nothing.
- R9: An in-order walk of the memory contents from root_addr gives every stored key in ascending order.
- R10: mem_en is 0 whenever idle=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Key offered |
| in_key | input | 14 | Offered key |
| in_ready | output | 1 | Engine can take a key this cycle |
| idle | output | 1 | No insertion in progress |
| root_addr | output | 6 | Address of the root node, 0 when empty |
| node_count | output | 6 | Number of nodes stored |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (when mem_en) |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 26 | Memory write word |
| mem_rdata | input | 26 | Read word, valid one cycle after a read |

## Verification
The assertions assume that mem_rdata returns the addressed word exactly one cycle after a read. They also assume that no other agent writes the memory while the engine is busy. The bench's memory model is a plain synchronous array that only this engine drives, so both assumptions hold. Keys are offered only in idle gaps, and every stored tree comes from stimulus that cannot exceed 63 nodes except in the test that fills the memory on purpose.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_WNEW,
    ST_PATCH
  } bst_state_t;
endpackage

// File: rtl/bst_key_filter.sv
module bst_key_filter #(
  parameter int KEY_W   = 14,
  parameter int KEY_MAX = 9999
) (
  input  logic [KEY_W-1:0] key,
  output logic             in_range
);
  function automatic logic f_in_range(input logic [KEY_W-1:0] k);
    return (32'(k) <= 32'(KEY_MAX));
  endfunction

  assign in_range = f_in_range(key);
endmodule

// File: rtl/bst_alloc.sv
module bst_alloc #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_ev,
  output logic [ADDR_W-1:0] count,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] root,
  output logic              full
);
  localparam int MAXN = (1 << ADDR_W) - 1;

  function automatic logic [ADDR_W-1:0] f_next(input logic [ADDR_W-1:0] c);
    return c + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      root  <= '0;
    end else if (alloc_ev) begin
      count <= f_next(count);
      if (count == '0) root <= ADDR_W'(1);
    end
  end

  assign next_addr = f_next(count);
  assign full      = (32'(count) == MAXN);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + ADDR_W'(1)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |-> !full);
  assert_root_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(root) != '0) |-> (root == $past(root)));
endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
#(
  parameter int KEY_W  = 14,
  parameter int ADDR_W = 6,
  localparam int WORD_W = KEY_W + 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  input  logic              key_ok,
  input  logic [ADDR_W-1:0] count,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] root,
  input  logic              full,
  output logic              alloc_ev,
  output logic              in_ready,
  output logic              idle,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  bst_state_t        state, state_n;
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] par_q, new_q;
  logic [WORD_W-1:0] pword_q;
  logic              right_q, first_q;

  function automatic logic [KEY_W-1:0] f_key(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: KEY_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_left(input logic [WORD_W-1:0] w);
    return w[2*ADDR_W-1 -: ADDR_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_right(input logic [WORD_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction
  function automatic logic f_go_right(input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] nk);
    return (k >= nk);
  endfunction
  function automatic logic [WORD_W-1:0] f_patch(input logic [WORD_W-1:0] w,
                                                input logic rgt, input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] r;
    r = w;
    if (rgt) r[ADDR_W-1:0] = a;
    else     r[2*ADDR_W-1 -: ADDR_W] = a;
    return r;
  endfunction

  logic              accept_ev, drop_ev, dir_rgt, walk_ev, leaf_ev;
  logic [ADDR_W-1:0] child;

  assign idle      = (state == ST_IDLE);
  assign in_ready  = idle && !full;
  assign accept_ev = in_ready && in_valid;
  assign drop_ev   = accept_ev && !key_ok;
  assign dir_rgt   = f_go_right(key_q, f_key(mem_rdata));
  assign child     = dir_rgt ? f_right(mem_rdata) : f_left(mem_rdata);
  assign walk_ev   = (state == ST_CMP) && (child != '0);
  assign leaf_ev   = (state == ST_CMP) && (child == '0);
  assign alloc_ev  = (state == ST_WNEW);

  always_comb begin
    state_n   = state;
    cur_n     = cur_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_IDLE: if (accept_ev && key_ok) begin
        if (count == '0) state_n = ST_WNEW;
        else begin
          state_n = ST_READ;
          cur_n   = root;
        end
      end
      ST_READ: begin
        mem_en   = 1'b1;
        mem_addr = cur_q;
        state_n  = ST_CMP;
      end
      ST_CMP: begin
        if (walk_ev) begin
          mem_en   = 1'b1;
          mem_addr = child;
          cur_n    = child;
        end else begin
          state_n = ST_WNEW;
        end
      end
      ST_WNEW: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = next_addr;
        mem_wdata = {key_q, {ADDR_W{1'b0}}, {ADDR_W{1'b0}}};
        state_n   = first_q ? ST_IDLE : ST_PATCH;
      end
      ST_PATCH: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = par_q;
        mem_wdata = f_patch(pword_q, right_q, new_q);
        state_n   = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      key_q   <= '0;
      cur_q   <= '0;
      par_q   <= '0;
      new_q   <= '0;
      pword_q <= '0;
      right_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state <= state_n;
      cur_q <= cur_n;
      if (accept_ev && key_ok) begin
        key_q   <= in_key;
        first_q <= (count == '0);
      end
      if (leaf_ev) begin
        par_q   <= cur_q;
        pword_q <= mem_rdata;
        right_q <= dir_rgt;
      end
      if (alloc_ev) new_q <= next_addr;
    end
  end

  assert_wr_nonnull_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr != '0));
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && key_ok) |=> !idle);
  assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (idle && !mem_en && $stable(count)));
  assert_idle_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_en);
  assert_patch_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PATCH) |-> (mem_wdata != pword_q));
endmodule

// File: rtl/bst_insert_engine.sv
module bst_insert_engine #(
  parameter int KEY_W   = 14,
  parameter int ADDR_W  = 6,
  parameter int KEY_MAX = 9999,
  localparam int WORD_W = KEY_W + 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  output logic              in_ready,
  output logic              idle,
  output logic [ADDR_W-1:0] root_addr,
  output logic [ADDR_W-1:0] node_count,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              key_ok, alloc_ev, full;
  logic [ADDR_W-1:0] next_addr;

  bst_key_filter #(.KEY_W(KEY_W), .KEY_MAX(KEY_MAX)) u_filt (
    .key(in_key), .in_range(key_ok));

  bst_alloc #(.ADDR_W(ADDR_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_ev(alloc_ev), .count(node_count),
    .next_addr(next_addr), .root(root_addr), .full(full));

  bst_ctrl #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .key_ok(key_ok), .count(node_count), .next_addr(next_addr),
    .root(root_addr), .full(full), .alloc_ev(alloc_ev), .in_ready(in_ready),
    .idle(idle), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));
endmodule

// File: tb/bst_insert_engine_tb.sv
module bst_insert_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_key = '0;
  logic        in_ready, idle, mem_en, mem_we;
  logic [5:0]  root_addr, node_count, mem_addr;
  logic [25:0] mem_wdata, mem_rdata;

  int vectors = 0, miscompares = 0, wr_cnt = 0, en_idle_viol = 0, cyc = 0;
  logic [25:0] mem [64];
  int m_key [64], m_l [64], m_r [64];
  int mcount = 0;
  int keys [64];
  int nkeys = 0;

  always #10 clk = ~clk;

  bst_insert_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .in_ready(in_ready), .idle(idle), .root_addr(root_addr),
    .node_count(node_count), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en && mem_we) wr_cnt <= wr_cnt + 1;
    if (rst_n && idle && mem_en) en_idle_viol <= en_idle_viol + 1;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_insert(input int k);
    int cur, d;
    if (k > 9999) return -1;
    mcount++;
    m_key[mcount] = k; m_l[mcount] = 0; m_r[mcount] = 0;
    keys[nkeys] = k; nkeys++;
    if (mcount == 1) return -1;
    cur = 1; d = 0;
    forever begin
      if (k >= m_key[cur]) begin
        if (m_r[cur] == 0) begin m_r[cur] = mcount; return d; end
        cur = m_r[cur];
      end else begin
        if (m_l[cur] == 0) begin m_l[cur] = mcount; return d; end
        cur = m_l[cur];
      end
      d++;
    end
  endfunction

  task automatic push(input int k, output int busy);
    @(negedge clk);
    in_valid = 1'b1; in_key = 14'(k);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    busy = 0;
    while (!idle) begin busy++; @(negedge clk); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mcount = 0; nkeys = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ins(input int k, input string req);
    int b, d;
    d = model_insert(k);
    push(k, b);
    if (d >= 0) check({req, " R7 latency"}, b, d + 4);
  endtask

  task automatic check_mem(input string req);
    int mism;
    mism = 0;
    for (int i = 1; i <= mcount; i++)
      if (mem[i] != {14'(m_key[i]), 6'(m_l[i]), 6'(m_r[i])}) begin
        if (mism == 0)
          $display("FAIL %s: node %0d actual %h expected %h", req, i, mem[i],
                   {14'(m_key[i]), 6'(m_l[i]), 6'(m_r[i])});
        mism++;
      end
    vectors++;
    if (mism != 0) miscompares++;
    check({req, " R5 count"}, int'(node_count), mcount);
  endtask

  task automatic check_sorted(input string req);
    int stk [64];
    int sp, cur, n, a;
    int srt [64];
    int bad;
    for (int i = 0; i < nkeys; i++) srt[i] = keys[i];
    for (int i = 0; i < nkeys; i++)
      for (int j = 0; j + 1 < nkeys - i; j++)
        if (srt[j] > srt[j+1]) begin a = srt[j]; srt[j] = srt[j+1]; srt[j+1] = a; end
    sp = 0; cur = int'(root_addr); n = 0; bad = 0;
    while ((cur != 0 || sp > 0) && n < 64) begin
      if (cur != 0) begin stk[sp] = cur; sp++; cur = int'(mem[cur][11:6]); end
      else begin
        sp--; cur = stk[sp];
        if (int'(mem[cur][25:12]) != srt[n]) bad++;
        n++;
        cur = int'(mem[cur][5:0]);
      end
    end
    check({req, " R9 walk length"}, n, nkeys);
    check({req, " R9 order errors"}, bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 idle", int'(idle), 1);
    check("R1 ready", int'(in_ready), 1);
    check("R1 count", int'(node_count), 0);
    check("R1 root", int'(root_addr), 0);
  endtask

  task automatic t_example();
    int seq [10] = '{19, 22, 17, 20, 35, 11, 21, 31, 15, 7};
    do_reset();
    foreach (seq[i]) ins(seq[i], "R4 example");
    check("R3 root", int'(root_addr), 1);
    check("R2 root key field", int'(mem[1][25:12]), 19);
    check_mem("R4 R5 example tree");
    check_sorted("example");
    ins(19, "R4 duplicate");
    ins(7, "R4 duplicate low");
    check_mem("R4 duplicates");
    check_sorted("duplicates");
    check("R3 root held", int'(root_addr), 1);
  endtask

  task automatic t_range();
    int w0, b;
    do_reset();
    ins(5000, "R6 seed");
    w0 = wr_cnt;
    push(10000, b);
    check("R6 drop busy cycles", b, 0);
    push(16383, b);
    check("R6 drop count", int'(node_count), 1);
    check("R6 drop writes", wr_cnt, w0);
    check("R6 ready", int'(in_ready), 1);
    ins(9999, "R6 top key");
    ins(0, "R6 zero key");
    check_mem("R6 range tree");
    check_sorted("range");
  endtask

  task automatic t_full();
    int k, w0;
    do_reset();
    k = 4321;
    for (int i = 0; i < 63; i++) begin
      ins(k, "R8 fill");
      k = (k * 73 + 1009) % 10000;
    end
    check("R8 count full", int'(node_count), 63);
    @(negedge clk);
    check("R8 ready low", int'(in_ready), 0);
    w0 = wr_cnt;
    in_valid = 1'b1; in_key = 14'd123;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 no write when full", wr_cnt, w0);
    check("R8 count held", int'(node_count), 63);
    check_mem("R8 full tree");
    check_sorted("full");
  endtask

  initial begin
    t_reset();
    t_example();
    t_range();
    t_full();
    check("R10 port quiet while idle", en_idle_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule